// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Combiner

Two IDE channels each raise a level-sensitive interrupt request. This block folds them into one level-sensitive PCI interrupt line. A byte-wide mode register keeps one pending flag and one mask flag per channel. Hardware drives the pending flags from the request levels. Software can write only the mask flags. The output is high when any channel is pending and not masked.

Software reaches the same register state through one byte-wide access port. The port has two views. In the configuration view, the mode register and two per-channel timing bytes sit at fixed addresses. In the bus-master view, a channel select and a two-bit slot offset pick the register. The timing bytes are plain read/write storage and have no effect on behaviour. Reads are combinational. Writes and request changes take effect at the next clock edge, and the interrupt output is registered.

Top module: `ide_irq_combiner`

## Requirements
- R1: While reset is asserted and after it is released, with no later write, the mode register and both timing bytes read 0 and `irq_out` is low.
- R2: The mode register bit 2 (channel 0) and bit 3 (channel 1) show the value that `chan_req[0]` and `chan_req[1]` had at the previous clock edge: set when the request was high, clear when it was low.
- R3: `irq_out` is a registered level equal to (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode register, taken from the state the register enters at that same clock edge. It therefore follows a request change or a mask write one cycle later.
- R4: A configuration-view write (`acc_bm`=0) to address 0x71 loads bits 5:4 of the mode register from `acc_wdata[5:4]` and changes no other bit. Bits 7:6 and 1:0 always read 0.
- R5: A bus-master-view write (`acc_bm`=1) to slot offset 1 acts on the mode register exactly as R4 does, whatever the value of `acc_chan`.
- R6: A read of configuration address 0x71, or of bus-master slot offset 1 for either channel, returns the current mode register.
- R7: Configuration address 0x73 is channel 0's timing byte and 0x7B is channel 1's. Bus-master slot offset 3 reads or replaces the whole timing byte of the channel chosen by `acc_chan`.
- R8: The values in the timing bytes never affect `irq_out`.
- R9: Other configuration addresses read 0x00. Bus-master slot offsets 0 and 2 read 0xFF. Writes to any of these change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 2 | Interrupt request levels, bit n for channel n |
| acc_bm | input | 1 | 1 selects the bus-master view, 0 selects the configuration view |
| acc_chan | input | 1 | Channel of the bus-master slot |
| acc_addr | input | 8 | Configuration address, or slot offset in bits 1:0 |
| acc_wr | input | 1 | Write strobe, sampled at the clock edge |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Combinational read data for the current address |
| irq_out | output | 1 | Combined interrupt level |

## Verification
The bench writes the mode register with every other bit set. A design that let those bits through would show spurious pending flags, or ones in the reserved positions, when the register is read back. It also raises a request while its channel is masked, then unmasks in the same cycle that the request drops. This exposes an output computed from stale register state, which glitches one cycle high or low. Timing-byte writes are made while an interrupt is asserted, and the slot offset is aliased across both channels. A design that crossed the timing bytes, or let them gate the interrupt, would then read back the wrong byte or move `irq_out`.

// File: rtl/ide_irq_combiner.sv
module ide_irq_combiner #(
  parameter logic [7:0] MODE_ADDR = 8'h71,
  parameter logic [7:0] TIM0_ADDR = 8'h73,
  parameter logic [7:0] TIM1_ADDR = 8'h7B,
  parameter int         NCH       = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic           acc_bm,
  input  logic           acc_chan,
  input  logic [7:0]     acc_addr,
  input  logic           acc_wr,
  input  logic [7:0]     acc_wdata,
  output logic [7:0]     acc_rdata,
  output logic           irq_out
);
  localparam logic [1:0] SLOT_MODE = 2'd1;
  localparam logic [1:0] SLOT_TIM  = 2'd3;

  logic [NCH-1:0] pend, mask, mask_nx;
  logic [7:0]     tim0, tim1, mode;
  logic           hit_mode, hit_t0, hit_t1;

  assign hit_mode = acc_bm ? (acc_addr[1:0] == SLOT_MODE) : (acc_addr == MODE_ADDR);
  assign hit_t0   = acc_bm ? (acc_addr[1:0] == SLOT_TIM && !acc_chan) : (acc_addr == TIM0_ADDR);
  assign hit_t1   = acc_bm ? (acc_addr[1:0] == SLOT_TIM &&  acc_chan) : (acc_addr == TIM1_ADDR);

  assign mask_nx = (acc_wr && hit_mode) ? acc_wdata[5:4] : mask;
  assign mode    = {2'b00, mask, pend, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      mask    <= '0;
      tim0    <= '0;
      tim1    <= '0;
      irq_out <= 1'b0;
    end else begin
      pend    <= chan_req;
      mask    <= mask_nx;
      irq_out <= |(chan_req & ~mask_nx);
      if (acc_wr && hit_t0) tim0 <= acc_wdata;
      if (acc_wr && hit_t1) tim1 <= acc_wdata;
    end
  end

  always_comb begin
    if (hit_mode)    acc_rdata = mode;
    else if (hit_t0) acc_rdata = tim0;
    else if (hit_t1) acc_rdata = tim1;
    else if (acc_bm) acc_rdata = 8'hFF;
    else             acc_rdata = 8'h00;
  end
endmodule

module ide_irq_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_req,
  input logic [1:0] pend,
  input logic [1:0] mask,
  input logic [7:0] tim0,
  input logic [7:0] tim1,
  input logic       acc_bm,
  input logic [7:0] acc_addr,
  input logic       acc_wr,
  input logic       irq_out
);
  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend == $past(chan_req));
  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(pend & ~mask));
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(mask));
  // R7
  timing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ($stable(tim0) && $stable(tim1)));
  // R9
  bm_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_bm && !acc_addr[0]) |=> ($stable(mask) && $stable(tim0) && $stable(tim1)));
endmodule

bind ide_irq_combiner ide_irq_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .pend(pend), .mask(mask),
  .tim0(tim0), .tim1(tim1), .acc_bm(acc_bm), .acc_addr(acc_addr),
  .acc_wr(acc_wr), .irq_out(irq_out)
);

// File: tb/test_ide_irq_combiner.sv
module test_ide_irq_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_req = '0;
  logic       acc_bm = 1'b0, acc_chan = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_addr = 8'h00, acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       irq_out;

  int vectors = 0, fails = 0;
  bit done = 0;

  int m_pend [2];
  int m_mask [2];
  int m_tim  [2];
  int m_irq;

  always #5 clk = ~clk;

  ide_irq_combiner i_ide_irq_combiner (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .acc_bm(acc_bm),
    .acc_chan(acc_chan), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_out(irq_out)
  );

  function automatic int model_read(bit bm, bit ch, int addr);
    int modev;
    modev = m_mask[1]*32 + m_mask[0]*16 + m_pend[1]*8 + m_pend[0]*4;
    if (bm) begin
      case (addr % 4)
        1: return modev;
        3: return m_tim[ch];
        default: return 255;
      endcase
    end
    if (addr == 'h71) return modev;
    if (addr == 'h73) return m_tim[0];
    if (addr == 'h7B) return m_tim[1];
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clock(bit [1:0] rq, bit bm, bit ch, int addr, bit wr, int wd);
    if (wr) begin
      if ((bm && addr % 4 == 1) || (!bm && addr == 'h71)) begin
        m_mask[0] = (wd >> 4) & 1;
        m_mask[1] = (wd >> 5) & 1;
      end else if (bm && addr % 4 == 3) m_tim[ch] = wd;
      else if (!bm && addr == 'h73) m_tim[0] = wd;
      else if (!bm && addr == 'h7B) m_tim[1] = wd;
    end
    m_pend[0] = rq[0];
    m_pend[1] = rq[1];
    m_irq = ((m_pend[0] && !m_mask[0]) || (m_pend[1] && !m_mask[1])) ? 1 : 0;
  endtask

  // Apply one cycle: drive at negedge, check reads and irq, clock, update model.
  task automatic step(string tag, bit [1:0] rq, bit bm, bit ch, int addr, bit wr, int wd);
    @(negedge clk);
    chan_req = rq; acc_bm = bm; acc_chan = ch; acc_addr = addr[7:0];
    acc_wr = wr; acc_wdata = wd[7:0];
    #1;
    check(tag, acc_rdata, model_read(bm, ch, addr));
    check("R3", irq_out, m_irq);
    @(posedge clk);
    model_clock(rq, bm, ch, addr, wr, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_pend[i] = 0; m_mask[i] = 0; m_tim[i] = 0; end
    m_irq = 0;
    // R1 reset state, reads during reset
    repeat (2) @(negedge clk);
    chan_req = 2'b11; acc_addr = 8'h71; #1; check("R1", acc_rdata, 0);
    acc_addr = 8'h73; #1; check("R1", acc_rdata, 0);
    acc_addr = 8'h7B; #1; check("R1", acc_rdata, 0);
    check("R1", irq_out, 0);
    chan_req = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    step("R1", 2'b00, 0, 0, 'h71, 0, 0);
    // R2, R3: each request pattern
    step("R2", 2'b01, 0, 0, 'h71, 0, 0);
    step("R2", 2'b10, 0, 0, 'h71, 0, 0);
    step("R2", 2'b11, 0, 0, 'h71, 0, 0);
    step("R2", 2'b00, 0, 0, 'h71, 0, 0);
    // R4: config mask write with all bits set
    step("R4", 2'b11, 0, 0, 'h71, 1, 'hFF);
    step("R4", 2'b11, 0, 0, 'h71, 1, 'hDF);
    step("R4", 2'b11, 0, 0, 'h71, 1, 'hCF);
    // R5: bus-master slot 1 write, both channels alias
    step("R5", 2'b11, 1, 1, 1, 1, 'h30);
    step("R6", 2'b11, 1, 0, 1, 0, 0);
    step("R5", 2'b01, 1, 0, 1, 1, 'h2F);
    step("R6", 2'b10, 1, 1, 1, 0, 0);
    // R3: unmask in the cycle the request drops
    step("R3", 2'b01, 0, 0, 'h71, 1, 'h10);
    step("R3", 2'b00, 0, 0, 'h71, 1, 'h00);
    step("R3", 2'b00, 0, 0, 'h71, 0, 0);
    // R7, R8: timing bytes while interrupt asserted
    step("R7", 2'b01, 0, 0, 'h73, 1, 'hA5);
    step("R8", 2'b01, 0, 0, 'h7B, 1, 'h3C);
    step("R7", 2'b01, 1, 0, 3, 0, 0);
    step("R7", 2'b01, 1, 1, 3, 0, 0);
    step("R7", 2'b01, 1, 1, 3, 1, 'hFF);
    step("R8", 2'b01, 1, 0, 3, 1, 'h00);
    step("R7", 2'b01, 0, 0, 'h7B, 0, 0);
    step("R7", 2'b01, 0, 0, 'h73, 0, 0);
    // R9: unmapped reads and writes
    step("R9", 2'b01, 1, 0, 0, 1, 'h30);
    step("R9", 2'b01, 1, 1, 2, 1, 'h30);
    step("R9", 2'b01, 0, 0, 'h72, 1, 'h30);
    step("R9", 2'b01, 0, 0, 'h00, 0, 0);
    step("R9", 2'b01, 0, 0, 'h71, 0, 0);
    // Random traffic, R6 readback
    for (int k = 0; k < 400; k++) begin
      int sel;
      int addr;
      sel = $urandom_range(0, 4);
      case (sel)
        0: addr = 'h71;
        1: addr = 'h73;
        2: addr = 'h7B;
        3: addr = $urandom_range(0, 255);
        default: addr = $urandom_range(0, 3);
      endcase
      step("R6", 2'($urandom_range(0, 3)), sel >= 4, 1'($urandom_range(0, 1)),
           addr, 1'($urandom_range(0, 1)), $urandom_range(0, 255));
    end
    step("R6", 2'b00, 0, 0, 'h71, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule